// File: doc/BRIEF.md
# Trace Cycle Frame Packer

The packer gathers per-cycle processor trace records and packs them into fixed 24-bit words for a trace buffer. Each record carries a 3-bit pipeline status, a packet field, a sync marker and a trigger marker. The configured port width sets how many records fit into one word. A 16-bit port gives one record per word, an 8-bit port gives two and a 4-bit port gives three. A word leaves the block once its last slot has been filled.

A trigger is carried inside the record itself. On a trigger cycle the status field holds a reserved code, and the real status moves into the low three bits of the packet field. A flush input closes a partly filled word, with its empty slots at zero. A port-mode input says whether the trace port is normal, demultiplexed or multiplexed. Records that arrive under an unsupported combination are dropped, and the `mode_bad` output reports that combination.

Top module: `trace_frame_packer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `frm_valid` is 0. No slot filled before a reset appears in any later word.
- R2: With `port_width`=2'b10 (16-bit), every accepted record produces a word in the next cycle. The layout is status in bits 2:0, packet[15:0] in bits 18:3 and sync in bit 19.
- R3: With `port_width`=2'b01 (8-bit), two accepted records make one word. The first record uses status 2:0, packet[7:0] 10:3 and sync 11. The second uses status 14:12, packet 22:15 and sync 23.
- R4: With `port_width`=2'b00 (4-bit), three accepted records make one word. Each slot is 8 bits wide at offsets 0, 8 and 16. Inside a slot, status is at +2:+0, packet[3:0] at +6:+3 and sync at +7.
- R5: A record with `cyc_trig`=1 places `TRIG_CODE` (default 3'b110) in its status field. Its packet field keeps its upper bits, and the low three bits of the packet field are replaced by the record's status.
- R6: With `flush`=1 and no record, a partly filled word is emitted in the next cycle with its unfilled slots at 0. When no slot is filled, no word is emitted. With `flush`=1 together with an accepted record, that record is included and the word is emitted.
- R7: `mode_bad` is 1 unless `port_mode`=2'b00 (normal) with a width code 00, 01 or 10, or `port_mode`=2'b01 (demultiplexed) with `port_width`=2'b01. Records offered while `mode_bad`=1 are dropped, and they never appear in a word.
- R8: Packet bits above the width of the selected port are ignored. Bits of the word above the last slot (23:20 in 16-bit mode) are 0.
- R9: A word appears on `frm_data` with `frm_valid`=1 for exactly the cycle after the record that fills its last slot, or after the flush. Without a record or a flush, `frm_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_width | input | 2 | 00 = 4-bit, 01 = 8-bit, 10 = 16-bit, 11 = invalid |
| port_mode | input | 2 | 00 = normal, 01 = demultiplexed, 10 = multiplexed, 11 = reserved |
| cyc_valid | input | 1 | A trace record is offered this cycle |
| cyc_stat | input | 3 | Pipeline status of the record |
| cyc_pkt | input | 16 | Packet field of the record |
| cyc_sync | input | 1 | Sync marker of the record |
| cyc_trig | input | 1 | The record is the trigger cycle |
| flush | input | 1 | Close the current partial word |
| mode_bad | output | 1 | Width and mode combination is not supported |
| frm_valid | output | 1 | One-cycle strobe: `frm_data` holds a new word |
| frm_data | output | 24 | Packed word |

## Verification
A wrong slot counter shows up at the ports as a word that appears one record early or one record late, or that holds a record in the wrong slot. The mismatch is visible on the first word emitted after the fault. Stale accumulator bits show up as nonzero bits in slots that should be empty, either in the next flushed word or in the first word after a reset. A fault in the trigger displacement or in the field shifts corrupts a specific bit range of the very next word. The vector table therefore compares the whole 24-bit word, every cycle, in each width.

// File: rtl/frame_pack_pkg.sv
package frame_pack_pkg;

  typedef enum logic [1:0] {
    PW_4  = 2'b00,
    PW_8  = 2'b01,
    PW_16 = 2'b10,
    PW_XX = 2'b11
  } port_width_e;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_DEMUX  = 2'b01,
    PM_MUX    = 2'b10,
    PM_RSVD   = 2'b11
  } port_mode_e;

  localparam int unsigned NUM_WIDTHS = 3;

  // index of the final slot of a word for each width
  function automatic logic [1:0] last_slot(input port_width_e w);
    case (w)
      PW_4:    last_slot = 2'd2;
      PW_8:    last_slot = 2'd1;
      default: last_slot = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/tfp_mode_check.sv
module tfp_mode_check
  import frame_pack_pkg::*;
(
  input  port_width_e width,
  input  port_mode_e  mode,
  output logic        bad
);
  logic ok;
  always_comb begin
    ok = 1'b0;
    if (mode == PM_NORMAL && width != PW_XX) ok = 1'b1;
    if (mode == PM_DEMUX  && width == PW_8)  ok = 1'b1;
    bad = ~ok;
  end
endmodule

// File: rtl/tfp_slot_encode.sv
module tfp_slot_encode
  import frame_pack_pkg::*;
#(
  parameter int unsigned STAT_W    = 3,
  parameter int unsigned PKT_W     = 16,
  parameter int unsigned FRAME_W   = 24,
  parameter logic [2:0]  TRIG_CODE = 3'b110
) (
  input  port_width_e        width,
  input  logic [1:0]         slot,
  input  logic [STAT_W-1:0]  stat,
  input  logic [PKT_W-1:0]   pkt,
  input  logic               sync,
  input  logic               trig,
  output logic [FRAME_W-1:0] placed
);
  logic [FRAME_W-1:0] cand [NUM_WIDTHS];

  for (genvar m = 0; m < NUM_WIDTHS; m++) begin : g_width
    localparam int unsigned PW     = PKT_W >> (NUM_WIDTHS - 1 - m);
    localparam int unsigned STRIDE = STAT_W + PW + 1;
    logic [PW-1:0]     pkt_eff;
    logic [STAT_W-1:0] st_eff;
    logic [STRIDE-1:0] field;
    always_comb begin
      pkt_eff = pkt[PW-1:0];
      st_eff  = stat;
      if (trig) begin
        pkt_eff[STAT_W-1:0] = stat;
        st_eff              = TRIG_CODE;
      end
      field   = {sync, pkt_eff, st_eff};
      cand[m] = FRAME_W'(field) << (32'(slot) * STRIDE);
    end
  end

  always_comb begin
    case (width)
      PW_4:    placed = cand[0];
      PW_8:    placed = cand[1];
      PW_16:   placed = cand[2];
      default: placed = '0;
    endcase
  end
endmodule

// File: rtl/tfp_accum.sv
module tfp_accum
  import frame_pack_pkg::*;
#(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  port_width_e        width,
  input  logic               take,
  input  logic               flush,
  input  logic [FRAME_W-1:0] placed,
  output logic [1:0]         slot,
  output logic               frm_valid,
  output logic [FRAME_W-1:0] frm_data
);
  logic [1:0]         slot_q, slot_d;
  logic [FRAME_W-1:0] acc_q, acc_d, data_q, data_d;
  logic               vld_q, vld_d, acc_en, data_en;
  logic [FRAME_W-1:0] merged;

  always_comb begin
    merged  = acc_q | placed;
    slot_d  = slot_q;
    acc_d   = acc_q;
    data_d  = data_q;
    vld_d   = 1'b0;
    acc_en  = 1'b0;
    data_en = 1'b0;
    if (take) begin
      acc_en = 1'b1;
      if (slot_q == last_slot(width) || flush) begin
        data_d  = merged;
        data_en = 1'b1;
        vld_d   = 1'b1;
        acc_d   = '0;
        slot_d  = 2'd0;
      end else begin
        acc_d  = merged;
        slot_d = slot_q + 2'd1;
      end
    end else if (flush && slot_q != 2'd0) begin
      acc_en  = 1'b1;
      data_d  = acc_q;
      data_en = 1'b1;
      vld_d   = 1'b1;
      acc_d   = '0;
      slot_d  = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 2'd0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (acc_en) begin
        slot_q <= slot_d;
        acc_q  <= acc_d;
      end
      if (data_en) data_q <= data_d;
    end
  end

  assign slot      = slot_q;
  assign frm_valid = vld_q;
  assign frm_data  = data_q;
endmodule

// File: rtl/trace_frame_packer.sv
module trace_frame_packer
  import frame_pack_pkg::*;
#(
  parameter int unsigned STAT_W    = 3,
  parameter int unsigned PKT_W     = 16,
  parameter int unsigned FRAME_W   = 24,
  parameter logic [2:0]  TRIG_CODE = 3'b110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         port_width,
  input  logic [1:0]         port_mode,
  input  logic               cyc_valid,
  input  logic [STAT_W-1:0]  cyc_stat,
  input  logic [PKT_W-1:0]   cyc_pkt,
  input  logic               cyc_sync,
  input  logic               cyc_trig,
  input  logic               flush,
  output logic               mode_bad,
  output logic               frm_valid,
  output logic [FRAME_W-1:0] frm_data
);
  port_width_e        width;
  port_mode_e         mode;
  logic [1:0]         slot;
  logic [FRAME_W-1:0] placed;
  logic               take;

  assign width = port_width_e'(port_width);
  assign mode  = port_mode_e'(port_mode);
  assign take  = cyc_valid & ~mode_bad;

  tfp_mode_check u_mode (
    .width (width),
    .mode  (mode),
    .bad   (mode_bad)
  );

  tfp_slot_encode #(
    .STAT_W(STAT_W), .PKT_W(PKT_W), .FRAME_W(FRAME_W), .TRIG_CODE(TRIG_CODE)
  ) u_enc (
    .width  (width),
    .slot   (slot),
    .stat   (cyc_stat),
    .pkt    (cyc_pkt),
    .sync   (cyc_sync),
    .trig   (cyc_trig),
    .placed (placed)
  );

  tfp_accum #(.FRAME_W(FRAME_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .width     (width),
    .take      (take),
    .flush     (flush),
    .placed    (placed),
    .slot      (slot),
    .frm_valid (frm_valid),
    .frm_data  (frm_data)
  );
endmodule

// File: rtl/tfp_checker.sv
module tfp_checker #(
  parameter int unsigned FRAME_W   = 24,
  parameter logic [2:0]  TRIG_CODE = 3'b110
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         port_width,
  input logic               cyc_valid,
  input logic               cyc_trig,
  input logic               flush,
  input logic               mode_bad,
  input logic               frm_valid,
  input logic [FRAME_W-1:0] frm_data
);
  // R7: dropped records never complete a word
  a_r7_bad_mode_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && mode_bad && !flush) |=> !frm_valid);

  // R2: a 16-bit record yields a word next cycle
  a_r2_word_per_record: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !mode_bad && port_width == 2'b10) |=> frm_valid);

  // R8: top bits above the single 16-bit slot are zero
  a_r8_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !mode_bad && port_width == 2'b10) |=> (frm_data[FRAME_W-1:20] == '0));

  // R5: trigger code sits in the status field
  a_r5_trig_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_trig && !mode_bad && port_width == 2'b10) |=> (frm_data[2:0] == TRIG_CODE));

  // R9: nothing offered, nothing emitted
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid && !flush) |=> !frm_valid);
endmodule

bind trace_frame_packer tfp_checker #(.FRAME_W(FRAME_W), .TRIG_CODE(TRIG_CODE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_width (port_width),
  .cyc_valid  (cyc_valid),
  .cyc_trig   (cyc_trig),
  .flush      (flush),
  .mode_bad   (mode_bad),
  .frm_valid  (frm_valid),
  .frm_data   (frm_data)
);

// File: tb/tb_trace_frame_packer.sv
module tb_trace_frame_packer;
  localparam time HALF = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  port_width, port_mode;
  logic        cyc_valid, cyc_sync, cyc_trig, flush;
  logic [2:0]  cyc_stat;
  logic [15:0] cyc_pkt;
  logic        mode_bad, frm_valid;
  logic [23:0] frm_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #HALF clk = ~clk;

  trace_frame_packer dut (
    .clk(clk), .rst_n(rst_n), .port_width(port_width), .port_mode(port_mode),
    .cyc_valid(cyc_valid), .cyc_stat(cyc_stat), .cyc_pkt(cyc_pkt),
    .cyc_sync(cyc_sync), .cyc_trig(cyc_trig), .flush(flush),
    .mode_bad(mode_bad), .frm_valid(frm_valid), .frm_data(frm_data)
  );

  typedef struct packed {
    logic        vld;
    logic [1:0]  w;
    logic [2:0]  st;
    logic [15:0] pkt;
    logic        sync;
    logic        trig;
    logic        fl;
    logic        ev;
    logic [23:0] ed;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'b10, 3'd5, 16'hABCD, 1'b1, 1'b0, 1'b0, 1'b1, 24'h0D5E6D}, // R2
    '{1'b1, 2'b10, 3'd2, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b1, 24'h009196}, // R5
    '{1'b1, 2'b01, 3'd1, 16'hFF3C, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000}, // R3, R8
    '{1'b1, 2'b01, 3'd7, 16'h0081, 1'b1, 1'b0, 1'b0, 1'b1, 24'hC0F1E1}, // R3
    '{1'b1, 2'b00, 3'd3, 16'h000A, 1'b1, 1'b0, 1'b0, 1'b0, 24'h000000}, // R4
    '{1'b1, 2'b00, 3'd0, 16'h0005, 1'b0, 1'b1, 1'b0, 1'b0, 24'h000000}, // R4, R5
    '{1'b1, 2'b00, 3'd4, 16'h000F, 1'b1, 1'b0, 1'b0, 1'b1, 24'hFC06D3}, // R4
    '{1'b1, 2'b00, 3'd2, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000}, // R6
    '{1'b0, 2'b00, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 24'h00000A}, // R6
    '{1'b0, 2'b00, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 24'h000000}, // R6
    '{1'b1, 2'b01, 3'd6, 16'h0012, 1'b1, 1'b0, 1'b1, 1'b1, 24'h000896}, // R6
    '{1'b0, 2'b01, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 24'h000000}  // R9
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] w, input logic [2:0] st,
                       input logic [15:0] pk, input logic sy, input logic tr, input logic fl);
    cyc_valid = v; port_width = w; cyc_stat = st; cyc_pkt = pk;
    cyc_sync = sy; cyc_trig = tr; flush = fl;
  endtask

  // drive at the falling edge, sample 1 ns after the next rising edge
  task automatic step_and_check(input string req, input logic ev, input logic [23:0] ed);
    @(posedge clk); #1ns;
    chk({req, " valid"}, 32'(frm_valid), 32'(ev));
    if (ev) chk({req, " data"}, 32'(frm_data), 32'(ed));
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    port_mode = 2'b00;
    drive(1'b0, 2'b10, 3'd0, 16'h0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #1ns;
    chk("R1 reset valid", 32'(frm_valid), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1ns;
    chk("R1 first cycle after reset", 32'(frm_valid), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].vld, VEC[i].w, VEC[i].st, VEC[i].pkt, VEC[i].sync, VEC[i].trig, VEC[i].fl);
      step_and_check($sformatf("R9 vec%0d", i), VEC[i].ev, VEC[i].ed);
    end

    // R7: multiplexed mode rejected, record dropped, nothing left to flush
    @(negedge clk);
    port_mode = 2'b10;
    drive(1'b1, 2'b01, 3'd7, 16'h00FF, 1'b1, 1'b0, 1'b0);
    #1ns chk("R7 mux flagged", 32'(mode_bad), 32'd1);
    step_and_check("R7 mux dropped", 1'b0, 24'h0);
    @(negedge clk);
    drive(1'b0, 2'b01, 3'd0, 16'h0, 1'b0, 1'b0, 1'b1);
    step_and_check("R7 nothing stored", 1'b0, 24'h0);

    // R7: demultiplexed needs 8-bit width
    @(negedge clk);
    port_mode = 2'b01;
    drive(1'b1, 2'b10, 3'd1, 16'h1111, 1'b0, 1'b0, 1'b0);
    #1ns chk("R7 demux 16-bit flagged", 32'(mode_bad), 32'd1);
    step_and_check("R7 demux 16-bit dropped", 1'b0, 24'h0);
    @(negedge clk);
    drive(1'b1, 2'b01, 3'd2, 16'h0000, 1'b0, 1'b0, 1'b0);
    #1ns chk("R7 demux 8-bit legal", 32'(mode_bad), 32'd0);
    step_and_check("R7 demux first slot", 1'b0, 24'h0);
    @(negedge clk);
    drive(1'b1, 2'b01, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b0);
    step_and_check("R7 demux word", 1'b1, 24'h800002);

    // R1: a slot filled before reset is lost
    @(negedge clk);
    port_mode = 2'b00;
    drive(1'b1, 2'b01, 3'd7, 16'h00FF, 1'b1, 1'b0, 1'b0);
    step_and_check("R1 pre-reset slot", 1'b0, 24'h0);
    @(negedge clk);
    drive(1'b0, 2'b01, 3'd0, 16'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(1'b1, 2'b01, 3'd1, 16'h0001, 1'b0, 1'b0, 1'b0);
    step_and_check("R1 slot cleared", 1'b0, 24'h0);
    @(negedge clk);
    drive(1'b1, 2'b01, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0);
    step_and_check("R1 clean word", 1'b1, 24'h000009);
    @(negedge clk);
    drive(1'b0, 2'b01, 3'd0, 16'h0, 1'b0, 1'b0, 1'b0);
    step_and_check("R9 single-cycle strobe", 1'b0, 24'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule